// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block turns one 6-bit operand specifier of a 16-bit, word-addressed processor into a resolved operand. The operand has a value. Where the operand is writable, the block also reports what kind of place holds it (a general register, a memory word, the stack pointer, the program counter or the overflow register) and the memory address when that place is memory. It also returns the program counter and stack pointer as they stand after the operand has been consumed. Fetch, execution and writeback sit in neighbouring blocks.

A requester raises `req` with the specifier and holds it, together with the register file, SP, PC and overflow inputs, until `done` is seen. Specifiers that need nothing from memory complete in the same cycle. The other specifiers use a single memory read port. Over that port the block fetches an extension word at PC, reads the operand word, or does both, in that order. It reports `done` in the cycle after the last read returns. Short inline literals, and the extension-word literal, are flagged so that a later write to them is thrown away.

Top module: `opm_unit`

## Requirements
- R1: Specifiers 0x00 to 0x07 select general register (spec & 7), with registers ordered A, B, C, X, Y, Z, I, J by index. The result is value = that register, kind = 0 (register), reg_idx = spec & 7, and PC and SP unchanged.
- R2: Specifiers 0x08 to 0x0f produce kind = 1 (memory). The effective address is the contents of register (spec & 7), and the value is the memory word at that address.
- R3: Specifiers 0x10 to 0x17 first read the extension word at PC and return pc_out = PC + 1. The effective address is that word plus register (spec & 7), and the value is the memory word at that address (kind 1).
- R4: Specifier 0x18 (pop) addresses memory at SP and returns sp_out = SP + 1. Specifier 0x19 (peek) addresses memory at SP and returns sp_out = SP. Both report kind 1.
- R5: Specifier 0x1a (push) returns sp_out = SP - 1 and addresses memory at that decremented value (kind 1).
- R6: Specifiers 0x1b, 0x1c and 0x1d give kind 2 (SP), 3 (PC) and 4 (overflow register) respectively. Their value is the current register contents, and they complete in the same cycle.
- R7: Specifier 0x1e reads the extension word at PC and uses it as a memory address (kind 1). Specifier 0x1f reads the extension word and uses it as the value (kind 5). Both return pc_out = PC + 1. Every other specifier leaves pc_out = PC.
- R8: Specifiers 0x20 to 0x3f give value = spec & 0x1f and kind 5 (literal). They set wr_drop, and 0x1f sets wr_drop as well. No other specifier sets wr_drop.
- R9: Register, special-register and short-literal specifiers assert done in the cycle req is seen, without a memory read. Memory-using specifiers hold mem_rd_en with a stable mem_addr until mem_rd_valid. The extension read comes before the operand read. done asserts exactly one cycle after the last mem_rd_valid.
- R10: All address and pointer arithmetic wraps modulo 2^16. Push at SP 0 addresses 0xffff, pop at SP 0xffff returns 0, and an extension read at PC 0xffff returns pc_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Resolve request, held until done |
| spec | input | 6 | Operand specifier |
| gpr_flat | input | 128 | Eight general registers, register n at bits 16n+15:16n |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Program counter pointing at the next extension word |
| ovf_in | input | 16 | Current overflow register |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rd_valid | input | 1 | Read data valid, one cycle per request |
| mem_rd_data | input | 16 | Read data |
| done | output | 1 | Result outputs valid this cycle |
| value | output | 16 | Operand value |
| kind | output | 3 | Target kind: 0 reg, 1 mem, 2 SP, 3 PC, 4 overflow, 5 literal |
| reg_idx | output | 3 | Register index for kind 0 |
| eff_addr | output | 16 | Effective address for kind 1 |
| wr_drop | output | 1 | Writes to this operand are discarded |
| pc_out | output | 16 | PC after the operand is consumed |
| sp_out | output | 16 | SP after the operand is consumed |

## Verification
The bench walks every one of the 64 specifiers with memory latencies of zero to two cycles. In each case it checks when done rises and the order and addresses of the reads. A design that counted the extension read into the operand read would report done early or read the wrong address. A design that post-decremented on push, or pre-incremented on pop, would address a word one away from the right one. Dedicated cases sit push at SP 0, pop at SP 0xffff, an extension read at PC 0xffff and indexing past the top of memory. Here a design without modular wraparound would give a wrong pointer or a wrong address, and a design that dropped the write flag on 0x1f would let a literal be overwritten.

// File: rtl/opm_pkg.sv
package opm_pkg;
    localparam int WORD_W = 16;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int SPEC_W = 6;
    localparam int LIT_W  = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        TK_REG = 3'd0,
        TK_MEM = 3'd1,
        TK_SP  = 3'd2,
        TK_PC  = 3'd3,
        TK_OVF = 3'd4,
        TK_LIT = 3'd5
    } tkind_e;

    typedef enum logic [3:0] {
        AM_REG, AM_IND, AM_IDX, AM_POP, AM_PEEK, AM_PUSH,
        AM_SP, AM_PC, AM_OVF, AM_NXA, AM_NXL, AM_LIT
    } amode_e;

    typedef struct packed {
        amode_e              mode;
        logic [RIDX_W-1:0]   ridx;
        logic [LIT_W-1:0]    lit;
        logic                use_ext;
        logic                use_mem;
    } dec_t;

    typedef struct packed {
        word_t  value;
        tkind_e kind;
        word_t  addr;
        word_t  pc_nx;
        word_t  sp_nx;
        logic   drop;
    } res_t;

    typedef enum logic [1:0] {S_IDLE, S_EXT, S_OPND, S_FIN} seq_e;
endpackage

// File: rtl/opm_decode.sv
module opm_decode
    import opm_pkg::*;
(
    input  logic [SPEC_W-1:0] spec,
    output dec_t              dec
);
    always_comb begin
        dec.ridx    = spec[RIDX_W-1:0];
        dec.lit     = spec[LIT_W-1:0];
        dec.use_ext = 1'b0;
        dec.use_mem = 1'b0;
        dec.mode    = AM_LIT;
        if (!spec[5]) begin
            unique case (spec[4:3])
                2'd0: dec.mode = AM_REG;
                2'd1: begin dec.mode = AM_IND; dec.use_mem = 1'b1; end
                2'd2: begin dec.mode = AM_IDX; dec.use_mem = 1'b1; dec.use_ext = 1'b1; end
                default: begin
                    unique case (spec[2:0])
                        3'd0: begin dec.mode = AM_POP;  dec.use_mem = 1'b1; end
                        3'd1: begin dec.mode = AM_PEEK; dec.use_mem = 1'b1; end
                        3'd2: begin dec.mode = AM_PUSH; dec.use_mem = 1'b1; end
                        3'd3: dec.mode = AM_SP;
                        3'd4: dec.mode = AM_PC;
                        3'd5: dec.mode = AM_OVF;
                        3'd6: begin dec.mode = AM_NXA; dec.use_mem = 1'b1; dec.use_ext = 1'b1; end
                        default: begin dec.mode = AM_NXL; dec.use_ext = 1'b1; end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/opm_resolve.sv
module opm_resolve
    import opm_pkg::*;
(
    input  dec_t  dec,
    input  word_t gpr [NREG],
    input  word_t sp,
    input  word_t pc,
    input  word_t ovf,
    input  word_t ext,
    input  word_t mdata,
    output res_t  res
);
    word_t sel;
    assign sel = gpr[dec.ridx];

    always_comb begin
        res.value = mdata;
        res.kind  = TK_MEM;
        res.addr  = '0;
        res.pc_nx = dec.use_ext ? word_t'(pc + word_t'(1)) : pc;
        res.sp_nx = sp;
        res.drop  = 1'b0;
        unique case (dec.mode)
            AM_REG:  begin res.value = sel; res.kind = TK_REG; end
            AM_IND:  res.addr = sel;
            AM_IDX:  res.addr = word_t'(ext + sel);
            AM_POP:  begin res.addr = sp; res.sp_nx = word_t'(sp + word_t'(1)); end
            AM_PEEK: res.addr = sp;
            AM_PUSH: begin
                res.addr  = word_t'(sp - word_t'(1));
                res.sp_nx = word_t'(sp - word_t'(1));
            end
            AM_SP:   begin res.value = sp;  res.kind = TK_SP;  end
            AM_PC:   begin res.value = pc;  res.kind = TK_PC;  end
            AM_OVF:  begin res.value = ovf; res.kind = TK_OVF; end
            AM_NXA:  res.addr = ext;
            AM_NXL:  begin res.value = ext; res.kind = TK_LIT; res.drop = 1'b1; end
            default: begin
                res.value = word_t'(dec.lit);
                res.kind  = TK_LIT;
                res.drop  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/opm_seq.sv
module opm_seq
    import opm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  logic  use_ext,
    input  logic  use_mem,
    input  word_t pc,
    input  word_t opnd_addr,
    input  logic  rd_valid,
    input  word_t rd_data,
    output logic  rd_en,
    output word_t rd_addr,
    output word_t ext_q,
    output word_t data_q,
    output logic  done
);
    seq_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (req) begin
                if (use_ext)      st_nx = S_EXT;
                else if (use_mem) st_nx = S_OPND;
            end
            S_EXT:  if (rd_valid) st_nx = use_mem ? S_OPND : S_FIN;
            S_OPND: if (rd_valid) st_nx = S_FIN;
            default: st_nx = S_IDLE;
        endcase
    end

    assign rd_en   = (st == S_EXT) || (st == S_OPND);
    assign rd_addr = (st == S_EXT) ? pc : opnd_addr;
    assign done    = (st == S_FIN) || ((st == S_IDLE) && req && !use_ext && !use_mem);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ext_q  <= '0;
            data_q <= '0;
        end else begin
            st <= st_nx;
            if (st == S_EXT && rd_valid)  ext_q  <= rd_data;
            if (st == S_OPND && rd_valid) data_q <= rd_data;
        end
    end
endmodule

// File: rtl/opm_unit.sv
module opm_unit
    import opm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [SPEC_W-1:0]      spec,
    input  logic [NREG*WORD_W-1:0] gpr_flat,
    input  logic [WORD_W-1:0]      sp_in,
    input  logic [WORD_W-1:0]      pc_in,
    input  logic [WORD_W-1:0]      ovf_in,
    output logic                   mem_rd_en,
    output logic [WORD_W-1:0]      mem_addr,
    input  logic                   mem_rd_valid,
    input  logic [WORD_W-1:0]      mem_rd_data,
    output logic                   done,
    output logic [WORD_W-1:0]      value,
    output logic [2:0]             kind,
    output logic [RIDX_W-1:0]      reg_idx,
    output logic [WORD_W-1:0]      eff_addr,
    output logic                   wr_drop,
    output logic [WORD_W-1:0]      pc_out,
    output logic [WORD_W-1:0]      sp_out
);
    word_t gpr [NREG];
    dec_t  dec;
    res_t  res;
    word_t ext_q, data_q;

    for (genvar g = 0; g < NREG; g++) begin : g_split
        assign gpr[g] = gpr_flat[g*WORD_W +: WORD_W];
    end

    opm_decode u_dec (.spec(spec), .dec(dec));

    opm_resolve u_res (
        .dec(dec), .gpr(gpr), .sp(sp_in), .pc(pc_in), .ovf(ovf_in),
        .ext(ext_q), .mdata(data_q), .res(res)
    );

    opm_seq u_seq (
        .clk(clk), .rst(rst), .req(req),
        .use_ext(dec.use_ext), .use_mem(dec.use_mem),
        .pc(pc_in), .opnd_addr(res.addr),
        .rd_valid(mem_rd_valid), .rd_data(mem_rd_data),
        .rd_en(mem_rd_en), .rd_addr(mem_addr),
        .ext_q(ext_q), .data_q(data_q), .done(done)
    );

    assign value    = res.value;
    assign kind     = res.kind;
    assign reg_idx  = dec.ridx;
    assign eff_addr = res.addr;
    assign wr_drop  = res.drop;
    assign pc_out   = res.pc_nx;
    assign sp_out   = res.sp_nx;
endmodule

// File: rtl/opm_unit_chk.sv
module opm_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic [5:0]  spec,
    input logic [15:0] sp_in,
    input logic [15:0] pc_in,
    input logic        mem_rd_en,
    input logic        mem_rd_valid,
    input logic        done,
    input logic [15:0] value,
    input logic [2:0]  kind,
    input logic [15:0] eff_addr,
    input logic        wr_drop,
    input logic [15:0] pc_out,
    input logic [15:0] sp_out
);
    logic ext_spec, mem_spec;
    assign ext_spec = (spec[5:3] == 3'b010) || (spec == 6'h1e) || (spec == 6'h1f);
    assign mem_spec = (spec[5:3] == 3'b001) || (spec[5:3] == 3'b010) ||
                      (spec == 6'h18) || (spec == 6'h19) || (spec == 6'h1a) || (spec == 6'h1e);

    AST_REG_DIRECT: assert property (@(posedge clk) disable iff (rst)
        done && spec[5:3] == 3'b000 |-> kind == 3'd0 && pc_out == pc_in && sp_out == sp_in); // R1
    AST_EXT_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        done && ext_spec |-> pc_out == 16'(pc_in + 16'd1)); // R3
    AST_PC_KEPT: assert property (@(posedge clk) disable iff (rst)
        done && !ext_spec |-> pc_out == pc_in); // R7
    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        done && spec == 6'h18 |-> eff_addr == sp_in && sp_out == 16'(sp_in + 16'd1)); // R4
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        done && spec == 6'h1a |-> sp_out == 16'(sp_in - 16'd1) && eff_addr == sp_out); // R5
    AST_LIT_DROP: assert property (@(posedge clk) disable iff (rst)
        done && spec[5] |-> wr_drop && kind == 3'd5 && value == {11'd0, spec[4:0]}); // R8
    AST_MEM_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        done && mem_spec |-> $past(mem_rd_valid) && !mem_rd_en); // R9
    AST_IMM_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req && !mem_rd_en && !ext_spec && !mem_spec |-> done); // R9
endmodule

bind opm_unit opm_unit_chk u_chk (.*);

// File: tb/opm_unit_test.sv
`timescale 1ns/1ps
module opm_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [5:0]  spec = '0;
    logic [127:0] gpr_flat = '0;
    logic [15:0] sp_in = '0, pc_in = '0, ovf_in = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        done;
    logic [15:0] value;
    logic [2:0]  kind;
    logic [2:0]  reg_idx;
    logic [15:0] eff_addr;
    logic        wr_drop;
    logic [15:0] pc_out, sp_out;

    int checks = 0, fails = 0;
    int lat = 0, mcnt = 0;
    logic [15:0] regs [8];

    always #5 clk = ~clk;

    opm_unit uut (.*);

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3c5a;
    endfunction

    always @(negedge clk) begin
        if (mem_rd_en) begin
            if (mcnt == lat) begin
                mem_rd_valid = 1'b1; mem_rd_data = memf(mem_addr); mcnt = 0;
            end else begin
                mem_rd_valid = 1'b0; mcnt++;
            end
        end else begin
            mem_rd_valid = 1'b0; mcnt = 0;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] s);
        if (s < 6'h08) return "R1";
        if (s < 6'h10) return "R2";
        if (s < 6'h18) return "R3";
        if (s == 6'h18 || s == 6'h19) return "R4";
        if (s == 6'h1a) return "R5";
        if (s < 6'h1e) return "R6";
        if (s < 6'h20) return "R7";
        return "R8";
    endfunction

    task automatic load_regs();
        for (int i = 0; i < 8; i++) gpr_flat[i*16 +: 16] = regs[i];
    endtask

    // Behavioural reference: expected outcome and cycle of done for one request.
    task automatic run_op(input logic [5:0] s, input int lat_i, input string extra);
        int nrd, exp_cyc, rdi, c;
        logic [15:0] ext, eff, val, pcn, spn, rda [2];
        logic [2:0] knd;
        logic drp;
        string t;
        t = (extra != "") ? extra : tag_of(s);
        ext = memf(pc_in);
        nrd = 0; eff = 16'h0; pcn = pc_in; spn = sp_in; drp = 1'b0; knd = 3'd1; val = 16'h0;
        if (s >= 6'h20) begin val = {11'd0, s[4:0]}; knd = 3'd5; drp = 1'b1; end
        else if (s < 6'h08) begin val = regs[s[2:0]]; knd = 3'd0; end
        else if (s < 6'h10) begin eff = regs[s[2:0]]; nrd = 1; end
        else if (s < 6'h18) begin eff = 16'(ext + regs[s[2:0]]); nrd = 2; pcn = 16'(pc_in + 1); end
        else case (s)
            6'h18: begin eff = sp_in; spn = 16'(sp_in + 1); nrd = 1; end
            6'h19: begin eff = sp_in; nrd = 1; end
            6'h1a: begin eff = 16'(sp_in - 1); spn = eff; nrd = 1; end
            6'h1b: begin val = sp_in;  knd = 3'd2; end
            6'h1c: begin val = pc_in;  knd = 3'd3; end
            6'h1d: begin val = ovf_in; knd = 3'd4; end
            6'h1e: begin eff = ext; nrd = 2; pcn = 16'(pc_in + 1); end
            default: begin val = ext; knd = 3'd5; drp = 1'b1; nrd = 1; pcn = 16'(pc_in + 1); end
        endcase
        if (knd == 3'd1) val = memf(eff);
        if (s[5:3] == 3'b010 || s == 6'h1e) begin rda[0] = pc_in; rda[1] = eff; end
        else if (s == 6'h1f) begin rda[0] = pc_in; rda[1] = 16'h0; end
        else begin rda[0] = eff; rda[1] = 16'h0; end
        exp_cyc = (nrd == 0) ? 0 : 1 + nrd * (lat_i + 1);
        lat = lat_i;
        spec = s; req = 1'b1;
        rdi = 0; c = 0;
        forever begin
            #1;
            if (mem_rd_valid) begin
                if (rdi < 2) chk("R9", $sformatf("read %0d address spec %h", rdi, s), mem_addr, rda[rdi]);
                rdi++;
            end
            if (done && c != exp_cyc) chk("R9", $sformatf("early done spec %h cycle %0d", s, c), 0, 1);
            if (c == exp_cyc) begin
                chk("R9", $sformatf("done spec %h", s), done, 1);
                chk("R9", $sformatf("read count spec %h", s), rdi, nrd);
                chk(t, $sformatf("value spec %h", s), value, val);
                chk(t, $sformatf("kind spec %h", s), kind, knd);
                chk("R8", $sformatf("wr_drop spec %h", s), wr_drop, drp);
                chk(t, $sformatf("pc_out spec %h", s), pc_out, pcn);
                chk(t, $sformatf("sp_out spec %h", s), sp_out, spn);
                if (knd == 3'd1) chk(t, $sformatf("eff_addr spec %h", s), eff_addr, eff);
                if (knd == 3'd0) chk("R1", $sformatf("reg_idx spec %h", s), reg_idx, s[2:0]);
                break;
            end
            if (c > 40) begin chk("R9", $sformatf("done timeout spec %h", s), 0, 1); break; end
            c++;
            @(negedge clk);
        end
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog expired: actual hung expected finished");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'(16'h1111 * (i + 1));
        load_regs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9", "reset done low", done, 0);
        chk("R9", "reset no read", mem_rd_en, 0);
        @(negedge clk);

        for (int pass = 0; pass < 3; pass++) begin
            for (int s = 0; s < 64; s++) begin
                for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
                load_regs();
                sp_in = 16'($urandom); pc_in = 16'($urandom); ovf_in = 16'($urandom);
                run_op(6'(s), pass, "");
            end
        end

        // R10: wraparound corners
        sp_in = 16'h0000; run_op(6'h1a, 1, "R10");
        sp_in = 16'hffff; run_op(6'h18, 0, "R10");
        sp_in = 16'hffff; run_op(6'h19, 2, "R10");
        pc_in = 16'hffff; run_op(6'h1f, 0, "R10");
        pc_in = 16'hffff; run_op(6'h1e, 1, "R10");
        regs[3] = 16'hffff; load_regs(); pc_in = 16'h1234;
        run_op(6'h13, 0, "R10");
        regs[7] = 16'hfffe; load_regs(); pc_in = 16'h00ff;
        run_op(6'h17, 2, "R10");

        summary();
    end
endmodule